// File: doc/BRIEF.md
# Predicated Stateful Update Atom

This block is a single-cycle read-modify-write engine for one state word inside a packet-processing pipeline stage. For each valid packet it receives two packet operands. Static configuration inputs shape the arithmetic. Up to three relational predicates are evaluated over the current state, the packet operands and configured constants. Their outcome selects one of up to four update branches. Each branch forms its result from a zero-or-state term and an operand chosen among the two packet operands and a constant, then adds or subtracts the two.

The stored word is presented on the output throughout the cycle in which a packet arrives, so the packet carries the value seen before its own update. The new value is committed at the clock edge that ends that cycle, and the next packet sees it at once. A mode input turns the same datapath into a plain read/write cell, an unconditional accumulator, a guarded accumulator, a two-way conditional updater (add only, or add/subtract), or a four-way nested conditional updater.

Top module: `stateful_update_atom`

## Requirements
- R1: After reset the stored word equals the parameter INIT_STATE, and `old_state` shows it.
- R2: `old_state` shows the stored value before the update in the cycle a valid packet is presented. The result is visible from the next cycle. Back-to-back packets each see the update made by the one before, so two consecutive +1 updates raise the word by 2.
- R3: While `in_valid` is low the stored word does not change, whatever the configuration and operands are.
- R4: Mode 0 (read/write): if branch 0's state flag is 1, the word is only read and stays unchanged. If the flag is 0, the word is overwritten with branch 0's selected operand.
- R5: Operand select encoding for branches and predicates: 0 picks `pkt_a`, 1 picks `pkt_b`, 2 or 3 picks that unit's constant. A branch's first term is the stored word when its state flag is 1, and zero when the flag is 0.
- R6: Mode 1 (accumulate) applies branch 0 to every valid packet, always as an addition even when the branch's subtract bit is set. Results wrap modulo 2^DATA_W.
- R7: Mode 2 (guarded accumulate) applies branch 0, as an addition, only when predicate 0 holds. Otherwise the word is held.
- R8: Mode 3 (two-way) applies branch 0 when predicate 0 holds and branch 1 when it does not. Both branches add, and subtract bits are ignored.
- R9: Mode 4 (two-way with subtract) selects branches as mode 3 but honours each branch's subtract bit. Subtraction wraps modulo 2^DATA_W.
- R10: Mode 5 (nested) chooses among branches 0–3 as follows. If predicate 0 holds, predicate 1 picks branch 0 (true) or branch 1 (false). If predicate 0 fails, predicate 2 picks branch 2 (true) or branch 3 (false). Subtract bits are honoured.
- R11: Relational codes compare unsigned values: 0 ==, 1 !=, 2 <, 3 >, 4 <=, 5 >=. Codes 6 and 7 never hold.
- R12: A predicate's left side is (stored word or zero, per its state flag) plus its left operand select. Its right side is its right operand select. A predicate can therefore depend on the stored word.
- R13: Modes 6 and 7 perform no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet present this cycle |
| pkt_a | input | DATA_W | Packet operand A |
| pkt_b | input | DATA_W | Packet operand B |
| cfg_mode | input | 3 | Update mode, 0..5 used |
| cfg_pr_use_state | input | 3 | Per predicate: add stored word to left side |
| cfg_pr_lsel | input | 6 | Per predicate: 2-bit left operand select |
| cfg_pr_rsel | input | 6 | Per predicate: 2-bit right operand select |
| cfg_pr_op | input | 9 | Per predicate: 3-bit relational code |
| cfg_pr_const | input | 3*DATA_W | Per predicate constant |
| cfg_br_use_state | input | 4 | Per branch: first term is stored word (1) or zero (0) |
| cfg_br_sel | input | 8 | Per branch: 2-bit operand select |
| cfg_br_sub | input | 4 | Per branch: subtract instead of add |
| cfg_br_const | input | 4*DATA_W | Per branch constant |
| old_state | output | DATA_W | Stored word before this cycle's update |

## Verification
The bench builds the block with DATA_W = 8 and INIT_STATE = 8'hA5. The narrow word puts wraparound within a few packets: an add from 8'hFF reaches zero, and a subtraction below zero reaches 8'hFD. It also makes operand values above 8'h7F easy to pick, so an unsigned comparison can be told apart from a signed one. The non-zero reset value separates a correct initial load from a plain clear.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int SEL_W  = 2;
  localparam int REL_W  = 3;
  localparam int MODE_W = 3;
  localparam int N_BR   = 4;
  localparam int N_PR   = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_RW     = 3'd0,
    MODE_RAW    = 3'd1,
    MODE_PRED   = 3'd2,
    MODE_IFELSE = 3'd3,
    MODE_SUB    = 3'd4,
    MODE_NEST   = 3'd5
  } atom_mode_e;

  typedef enum logic [REL_W-1:0] {
    REL_EQ = 3'd0,
    REL_NE = 3'd1,
    REL_LT = 3'd2,
    REL_GT = 3'd3,
    REL_LE = 3'd4,
    REL_GE = 3'd5
  } atom_rel_e;

  typedef enum logic [SEL_W-1:0] {
    OPD_PKT_A = 2'd0,
    OPD_PKT_B = 2'd1,
    OPD_CONST = 2'd2
  } atom_opd_e;
endpackage

// File: rtl/atom_pred.sv
module atom_pred
  import atom_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] state,
  input  logic [DATA_W-1:0] pkt_a,
  input  logic [DATA_W-1:0] pkt_b,
  input  logic              use_state,
  input  logic [SEL_W-1:0]  lsel,
  input  logic [SEL_W-1:0]  rsel,
  input  logic [REL_W-1:0]  op,
  input  logic [DATA_W-1:0] kval,
  output logic              hit
);
  function automatic logic [DATA_W-1:0] pick(input logic [SEL_W-1:0] s,
                                             input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b,
                                             input logic [DATA_W-1:0] k);
    case (s)
      OPD_PKT_A: pick = a;
      OPD_PKT_B: pick = b;
      default:   pick = k;
    endcase
  endfunction

  function automatic logic compare(input logic [REL_W-1:0] code,
                                   input logic [DATA_W-1:0] l,
                                   input logic [DATA_W-1:0] r);
    case (code)
      REL_EQ:  compare = (l == r);
      REL_NE:  compare = (l != r);
      REL_LT:  compare = (l <  r);
      REL_GT:  compare = (l >  r);
      REL_LE:  compare = (l <= r);
      REL_GE:  compare = (l >= r);
      default: compare = 1'b0;
    endcase
  endfunction

  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;

  assign lhs = (use_state ? state : '0) + pick(lsel, pkt_a, pkt_b, kval);
  assign rhs = pick(rsel, pkt_a, pkt_b, kval);
  assign hit = compare(op, lhs, rhs);
endmodule

// File: rtl/atom_branch.sv
module atom_branch
  import atom_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] state,
  input  logic [DATA_W-1:0] pkt_a,
  input  logic [DATA_W-1:0] pkt_b,
  input  logic              use_state,
  input  logic [SEL_W-1:0]  sel,
  input  logic              sub_req,
  input  logic              sub_ok,
  input  logic [DATA_W-1:0] kval,
  output logic [DATA_W-1:0] value
);
  function automatic logic [DATA_W-1:0] combine(input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y,
                                                input logic              minus);
    combine = minus ? (x - y) : (x + y);
  endfunction

  logic [DATA_W-1:0] first_term;
  logic [DATA_W-1:0] second_term;

  assign first_term = use_state ? state : '0;

  always_comb begin
    case (sel)
      OPD_PKT_A: second_term = pkt_a;
      OPD_PKT_B: second_term = pkt_b;
      default:   second_term = kval;
    endcase
  end

  assign value = combine(first_term, second_term, sub_req & sub_ok);
endmodule

// File: rtl/atom_select.sv
module atom_select
  import atom_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [MODE_W-1:0]      mode,
  input  logic                   rw_read,
  input  logic [N_PR-1:0]        pred,
  input  logic [N_BR*DATA_W-1:0] br_val,
  output logic [N_BR-1:0]        br_hot,
  output logic                   upd_en,
  output logic [DATA_W-1:0]      next_val
);
  always_comb begin
    case (mode)
      MODE_RW:     br_hot = rw_read ? 4'b0000 : 4'b0001;
      MODE_RAW:    br_hot = 4'b0001;
      MODE_PRED:   br_hot = pred[0] ? 4'b0001 : 4'b0000;
      MODE_IFELSE,
      MODE_SUB:    br_hot = pred[0] ? 4'b0001 : 4'b0010;
      MODE_NEST:   br_hot = pred[0] ? (pred[1] ? 4'b0001 : 4'b0010)
                                    : (pred[2] ? 4'b0100 : 4'b1000);
      default:     br_hot = 4'b0000;
    endcase
  end

  assign upd_en = in_valid & (|br_hot);

  always_comb begin
    next_val = '0;
    for (int i = 0; i < N_BR; i++) begin
      if (br_hot[i]) next_val = next_val | br_val[i*DATA_W +: DATA_W];
    end
  end

  AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(br_hot)); // R10
  AST_SHALLOW_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_NEST) |-> (br_hot[3:2] == 2'b00)); // R8
  AST_IDLE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !upd_en); // R3
endmodule

// File: rtl/stateful_update_atom.sv
module stateful_update_atom
  import atom_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] INIT_STATE = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        pkt_a,
  input  logic [DATA_W-1:0]        pkt_b,
  input  logic [MODE_W-1:0]        cfg_mode,
  input  logic [N_PR-1:0]          cfg_pr_use_state,
  input  logic [N_PR*SEL_W-1:0]    cfg_pr_lsel,
  input  logic [N_PR*SEL_W-1:0]    cfg_pr_rsel,
  input  logic [N_PR*REL_W-1:0]    cfg_pr_op,
  input  logic [N_PR*DATA_W-1:0]   cfg_pr_const,
  input  logic [N_BR-1:0]          cfg_br_use_state,
  input  logic [N_BR*SEL_W-1:0]    cfg_br_sel,
  input  logic [N_BR-1:0]          cfg_br_sub,
  input  logic [N_BR*DATA_W-1:0]   cfg_br_const,
  output logic [DATA_W-1:0]        old_state
);
  logic [DATA_W-1:0]      state_q;
  logic [N_PR-1:0]        pred_hit;
  logic [N_BR*DATA_W-1:0] br_val;
  logic [N_BR-1:0]        br_hot;
  logic                   upd_en;
  logic [DATA_W-1:0]      next_val;
  logic                   sub_ok;

  assign sub_ok = (cfg_mode == MODE_SUB) || (cfg_mode == MODE_NEST);

  for (genvar p = 0; p < N_PR; p++) begin : g_pred
    atom_pred #(.DATA_W(DATA_W)) pred_i (
      .state     (state_q),
      .pkt_a     (pkt_a),
      .pkt_b     (pkt_b),
      .use_state (cfg_pr_use_state[p]),
      .lsel      (cfg_pr_lsel[p*SEL_W +: SEL_W]),
      .rsel      (cfg_pr_rsel[p*SEL_W +: SEL_W]),
      .op        (cfg_pr_op[p*REL_W +: REL_W]),
      .kval      (cfg_pr_const[p*DATA_W +: DATA_W]),
      .hit       (pred_hit[p])
    );
  end

  for (genvar b = 0; b < N_BR; b++) begin : g_branch
    atom_branch #(.DATA_W(DATA_W)) branch_i (
      .state     (state_q),
      .pkt_a     (pkt_a),
      .pkt_b     (pkt_b),
      .use_state (cfg_br_use_state[b]),
      .sel       (cfg_br_sel[b*SEL_W +: SEL_W]),
      .sub_req   (cfg_br_sub[b]),
      .sub_ok    (sub_ok),
      .kval      (cfg_br_const[b*DATA_W +: DATA_W]),
      .value     (br_val[b*DATA_W +: DATA_W])
    );
  end

  atom_select #(.DATA_W(DATA_W)) select_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .mode     (cfg_mode),
    .rw_read  (cfg_br_use_state[0]),
    .pred     (pred_hit),
    .br_val   (br_val),
    .br_hot   (br_hot),
    .upd_en   (upd_en),
    .next_val (next_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= INIT_STATE;
    else if (upd_en) state_q <= next_val;
  end

  assign old_state = state_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(old_state)); // R3
  AST_COMMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (old_state == $past(next_val))); // R2
  AST_FALSE_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_mode == MODE_PRED && !pred_hit[0]) |=> $stable(old_state)); // R7
  AST_ACCUM_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_mode == MODE_RAW) |-> upd_en); // R6
  AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode > MODE_NEST) |-> !upd_en); // R13
  AST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == MODE_RW && cfg_br_use_state[0]) |=> $stable(old_state)); // R4
endmodule

// File: tb/stateful_update_atom_tb_top.sv
`timescale 1ns/1ps
module stateful_update_atom_tb_top;
  localparam int W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [W-1:0]    pkt_a, pkt_b;
  logic [2:0]      cfg_mode;
  logic [2:0]      cfg_pr_use_state;
  logic [5:0]      cfg_pr_lsel, cfg_pr_rsel;
  logic [8:0]      cfg_pr_op;
  logic [3*W-1:0]  cfg_pr_const;
  logic [3:0]      cfg_br_use_state;
  logic [7:0]      cfg_br_sel;
  logic [3:0]      cfg_br_sub;
  logic [4*W-1:0]  cfg_br_const;
  logic [W-1:0]    old_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  stateful_update_atom #(.DATA_W(W), .INIT_STATE(8'hA5)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pkt_a(pkt_a), .pkt_b(pkt_b),
    .cfg_mode(cfg_mode), .cfg_pr_use_state(cfg_pr_use_state),
    .cfg_pr_lsel(cfg_pr_lsel), .cfg_pr_rsel(cfg_pr_rsel), .cfg_pr_op(cfg_pr_op),
    .cfg_pr_const(cfg_pr_const), .cfg_br_use_state(cfg_br_use_state),
    .cfg_br_sel(cfg_br_sel), .cfg_br_sub(cfg_br_sub), .cfg_br_const(cfg_br_const),
    .old_state(old_state)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: old_state actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_pred(input int i, input logic us, input logic [1:0] ls,
                          input logic [1:0] rs, input logic [2:0] op, input logic [W-1:0] k);
    cfg_pr_use_state[i] = us;
    cfg_pr_lsel[i*2 +: 2] = ls;
    cfg_pr_rsel[i*2 +: 2] = rs;
    cfg_pr_op[i*3 +: 3] = op;
    cfg_pr_const[i*W +: W] = k;
  endtask

  task automatic set_br(input int i, input logic us, input logic [1:0] sel,
                        input logic sub, input logic [W-1:0] k);
    cfg_br_use_state[i] = us;
    cfg_br_sel[i*2 +: 2] = sel;
    cfg_br_sub[i] = sub;
    cfg_br_const[i*W +: W] = k;
  endtask

  // Present one packet, check the pre-update value, advance one cycle.
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] exp_old, input string tag);
    pkt_a = a; pkt_b = b; in_valid = 1'b1;
    #1 check(old_state, exp_old, tag);
    @(negedge clk);
  endtask

  task automatic idle_check(input logic [W-1:0] exp, input string tag);
    in_valid = 1'b0;
    #1 check(old_state, exp, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; pkt_a = '0; pkt_b = '0; cfg_mode = 3'd0;
    cfg_pr_use_state = '0; cfg_pr_lsel = '0; cfg_pr_rsel = '0; cfg_pr_op = '0;
    cfg_pr_const = '0; cfg_br_use_state = '0; cfg_br_sel = '0; cfg_br_sub = '0;
    cfg_br_const = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(old_state, 8'hA5, "R1 reset value");
    @(negedge clk);
    check(old_state, 8'hA5, "R1 value held after reset");
  endtask

  task automatic t_read_write;
    cfg_mode = 3'd0;
    set_br(0, 1'b0, 2'd0, 1'b0, 8'h00);
    send(8'h10, 8'h00, 8'hA5, "R4 write pkt_a");
    set_br(0, 1'b1, 2'd0, 1'b0, 8'h00);
    send(8'h77, 8'h00, 8'h10, "R4 read-only after write");
    send(8'h77, 8'h00, 8'h10, "R4 read-only left word unchanged");
    set_br(0, 1'b0, 2'd1, 1'b0, 8'h00);
    send(8'h00, 8'h33, 8'h10, "R5 write pkt_b select");
    set_br(0, 1'b0, 2'd2, 1'b0, 8'h44);
    send(8'h00, 8'h00, 8'h33, "R5 write constant select");
    idle_check(8'h44, "R5 constant written");
  endtask

  task automatic t_idle_hold;
    cfg_mode = 3'd1;
    set_br(0, 1'b1, 2'd2, 1'b0, 8'h01);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(old_state, 8'h44, "R3 hold while invalid");
  endtask

  task automatic t_accumulate;
    cfg_mode = 3'd1;
    set_br(0, 1'b1, 2'd2, 1'b1, 8'h01); // subtract bit set but ignored
    send(8'h00, 8'h00, 8'h44, "R2 first increment sees old");
    send(8'h00, 8'h00, 8'h45, "R2 back-to-back sees prior update");
    idle_check(8'h46, "R6 two increments give +2, add only");
  endtask

  task automatic t_guarded;
    cfg_mode = 3'd2;
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd2, 8'h00); // state < pkt_a
    set_br(0, 1'b1, 2'd1, 1'b0, 8'h00);         // state + pkt_b
    send(8'h50, 8'h03, 8'h46, "R7 predicate true adds");
    send(8'h40, 8'h03, 8'h49, "R7 predicate false");
    send(8'h90, 8'h02, 8'h49, "R11 unsigned compare, false held");
    idle_check(8'h4B, "R11 unsigned 0x49<0x90 true");
  endtask

  task automatic t_ifelse;
    cfg_mode = 3'd3;
    set_pred(0, 1'b0, 2'd0, 2'd2, 3'd5, 8'h10); // pkt_a >= 0x10
    set_br(0, 1'b1, 2'd2, 1'b0, 8'h02);
    set_br(1, 1'b0, 2'd1, 1'b1, 8'h00);         // 0 + pkt_b, sub ignored
    send(8'h20, 8'h00, 8'h4B, "R8 true branch");
    send(8'h05, 8'h07, 8'h4D, "R8 true branch result");
    idle_check(8'h07, "R8 false branch adds, sub ignored");
  endtask

  task automatic t_subtract;
    cfg_mode = 3'd4;
    set_br(1, 1'b1, 2'd2, 1'b1, 8'h0A);
    send(8'h00, 8'h00, 8'h07, "R9 false branch");
    send(8'h30, 8'h00, 8'hFD, "R9 subtract wraps below zero");
    idle_check(8'hFF, "R9 true branch adds");
    cfg_mode = 3'd1;
    set_br(0, 1'b1, 2'd2, 1'b0, 8'h01);
    send(8'h00, 8'h00, 8'hFF, "R6 accumulate at top");
    idle_check(8'h00, "R6 add wraps to zero");
  endtask

  task automatic t_nested;
    cfg_mode = 3'd5;
    set_pred(0, 1'b0, 2'd0, 2'd2, 3'd0, 8'h01); // pkt_a == 1
    set_pred(1, 1'b1, 2'd2, 2'd1, 3'd1, 8'h00); // state != pkt_b
    set_pred(2, 1'b1, 2'd2, 2'd1, 3'd3, 8'h00); // state > pkt_b
    set_br(0, 1'b1, 2'd2, 1'b0, 8'h10);
    set_br(1, 1'b1, 2'd1, 1'b1, 8'h00);
    set_br(2, 1'b0, 2'd2, 1'b0, 8'h20);
    set_br(3, 1'b1, 2'd2, 1'b1, 8'h01);
    send(8'h01, 8'h05, 8'h00, "R10 branch 0");
    send(8'h01, 8'h10, 8'h10, "R10 branch 1 taken next");
    send(8'h00, 8'h00, 8'h00, "R10 branch 3 taken next");
    send(8'h00, 8'h05, 8'hFF, "R10 branch 2 taken next");
    idle_check(8'h20, "R10 branch 2 result");
  endtask

  task automatic t_relops;
    cfg_mode = 3'd2;
    set_br(0, 1'b1, 2'd2, 1'b0, 8'h01);
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd0, 8'h00);
    send(8'h20, 8'h00, 8'h20, "R11 eq");
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd1, 8'h00);
    send(8'h21, 8'h00, 8'h21, "R11 eq true incremented");
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd3, 8'h00);
    send(8'h20, 8'h00, 8'h21, "R11 ne false held");
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd4, 8'h00);
    send(8'h22, 8'h00, 8'h22, "R11 gt true");
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd5, 8'h00);
    send(8'h24, 8'h00, 8'h23, "R11 le true");
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd2, 8'h00);
    send(8'h23, 8'h00, 8'h23, "R11 ge false held");
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd6, 8'h00);
    send(8'h00, 8'h00, 8'h23, "R11 lt false held");
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd7, 8'h00);
    send(8'hFF, 8'h00, 8'h23, "R11 code 6 never holds");
    idle_check(8'h23, "R11 code 7 never holds");
  endtask

  task automatic t_lhs_offset;
    cfg_mode = 3'd2;
    set_pred(0, 1'b1, 2'd2, 2'd0, 3'd0, 8'h10); // state + 0x10 == pkt_a
    send(8'h33, 8'h00, 8'h23, "R12 state-dependent predicate");
    send(8'h33, 8'h00, 8'h24, "R12 match updated");
    idle_check(8'h24, "R12 changed state breaks match");
  endtask

  task automatic t_reserved;
    set_br(0, 1'b1, 2'd2, 1'b0, 8'h01);
    cfg_mode = 3'd6;
    send(8'h00, 8'h00, 8'h24, "R13 mode 6");
    cfg_mode = 3'd7;
    send(8'h00, 8'h00, 8'h24, "R13 mode 6 no update");
    idle_check(8'h24, "R13 mode 7 no update");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_read_write();
    t_idle_hold();
    t_accumulate();
    t_guarded();
    t_ifelse();
    t_subtract();
    t_nested();
    t_relops();
    t_lhs_offset();
    t_reserved();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule